// File: doc/BRIEF.md
# PWM Input Period and Pulse Meter

This block times an external digital waveform that arrives on one input pin. After a two-stage synchroniser the input is split into rising and falling edge events. One polarity is chosen as the trigger edge. It restarts a free-running counter from zero. The counter value that was reached just before the restart is stored, so that capture register holds the period. The opposite edge stores the count reached since the last trigger, so the other register holds the time spent in the trigger-active level. This is the high time when the trigger edge is rising and the low time when it is falling.

A configuration bit selects the trigger polarity. A second bit swaps which capture register takes the period and which takes the pulse length. Each channel has a capture enable, a capture flag with a clear strobe, an overcapture flag and an interrupt enable. A single interrupt line is the OR of the enabled flags. If no trigger edge arrives for a full counter range, the counter stops at its maximum and an overflow flag is raised. Both the counter and the flag are released by the next trigger edge.

Top module: `pwm_meter`

## Requirements
- R1: An input transition that is stable before a rising clock edge leads to a capture at the third rising clock edge. The capture flag is visible after that edge and not after the second one.
- R2: A trigger edge loads the counter value into the period channel and restarts the counter from 0 in the same cycle. The period register therefore reads N-1 for trigger edges that are N clock cycles apart.
- R3: Without a trigger edge, the counter stops at 2^CNT_W-1 and `ovf_flag` is set. A later trigger captures 2^CNT_W-1 and clears `ovf_flag` at the same clock edge.
- R4: The opposite edge loads the pulse channel with M-1, where M is the number of cycles from the trigger edge to the opposite edge.
- R5: `trig_on_fall`=0 makes the rising edge the trigger. `trig_on_fall`=1 makes the falling edge the trigger, so the pulse value is then the low time.
- R6: With `swap_route`=0, channel 0 (`cap_val_a`) captures on the trigger edge and channel 1 (`cap_val_b`) captures on the opposite edge. With `swap_route`=1 the two are exchanged.
- R7: While `cap_en[i]`=0, the value of channel i is left unchanged and its flag is not set.
- R8: A capture sets `cap_flag[i]`. A one-cycle `flag_clr[i]` clears the flag. When a capture and a clear fall in the same cycle, the flag ends up set.
- R9: `ovc_flag[i]` is set when channel i captures while `cap_flag[i]` is already set and not being cleared in that cycle. `flag_clr[i]` clears it.
- R10: `irq` is 1 exactly when some channel has both `cap_flag[i]` and `irq_en[i]` set.
- R11: After synchronous reset, both capture values, all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous waveform to be measured |
| trig_on_fall | input | 1 | 0: rising edge is trigger, 1: falling edge is trigger |
| swap_route | input | 1 | 0: channel 0 takes period, 1: channel 1 takes period |
| cap_en | input | 2 | Per-channel capture enable |
| irq_en | input | 2 | Per-channel interrupt enable |
| flag_clr | input | 2 | Per-channel strobe clearing capture and overcapture flags |
| cap_val_a | output | CNT_W | Channel 0 captured count |
| cap_val_b | output | CNT_W | Channel 1 captured count |
| cap_flag | output | 2 | Per-channel capture-event flag |
| ovc_flag | output | 2 | Per-channel overcapture flag |
| ovf_flag | output | 1 | Counter reached its maximum without a trigger |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the exact latency of an edge. A synchroniser stage too many or too few would move the flag by one cycle. It also checks the off-by-one of capture-before-restart: a design that restarts first would read 0 or N instead of N-1. Both polarities, both routings and one-cycle levels are covered. Further directed cases cover these points:
- A clear that meets a capture, where a design with the priority reversed would lose the event.
- An overcapture, which a design that ignores the pending flag would miss.
- A disabled channel, which must keep its old value.
- Counter saturation, where a wrapping counter would capture a small value instead of the maximum.

// File: rtl/pwmm_pkg.sv
package pwmm_pkg;

    localparam int NUM_CH = 2;

    // Raw edge events seen after synchronisation
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Edge events in measurement terms
    typedef struct packed {
        logic trig;
        logic opp;
    } meas_evt_t;

    function automatic meas_evt_t classify_edges(edge_pair_t e, logic trig_fall);
        meas_evt_t r;
        r.trig = trig_fall ? e.fall : e.rise;
        r.opp  = trig_fall ? e.rise : e.fall;
        return r;
    endfunction

    // Bit 0 feeds channel 0, bit 1 feeds channel 1
    function automatic logic [NUM_CH-1:0] route_events(meas_evt_t m, logic swap);
        logic [NUM_CH-1:0] r;
        r[0] = swap ? m.opp  : m.trig;
        r[1] = swap ? m.trig : m.opp;
        return r;
    endfunction

endpackage

// File: rtl/pwmm_sync_edge.sv
module pwmm_sync_edge
    import pwmm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_in,
    output edge_pair_t edges
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[MSB];
        end
    end

    always_comb begin
        edges.rise = sync_q[MSB] & ~last_q;
        edges.fall = ~sync_q[MSB] & last_q;
    end
endmodule

// File: rtl/pwmm_counter.sv
module pwmm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (restart) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (count == CNT_MAX) begin
            sat   <= 1'b1;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pwmm_capture_ch.sv
module pwmm_capture_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             enable,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic             ovc
);
    logic take;
    logic flag_n;
    logic ovc_n;

    assign take = evt & enable;

    always_comb begin
        flag_n = flag;
        ovc_n  = ovc;
        if (clr) begin
            flag_n = 1'b0;
            ovc_n  = 1'b0;
        end
        if (take) begin
            flag_n = 1'b1;
            if (flag && !clr) begin
                ovc_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flag  <= 1'b0;
            ovc   <= 1'b0;
        end else begin
            if (take) begin
                value <= count;
            end
            flag <= flag_n;
            ovc  <= ovc_n;
        end
    end
endmodule

// File: rtl/pwm_meter.sv
module pwm_meter
    import pwmm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic              trig_on_fall,
    input  logic              swap_route,
    input  logic [NUM_CH-1:0] cap_en,
    input  logic [NUM_CH-1:0] irq_en,
    input  logic [NUM_CH-1:0] flag_clr,
    output logic [CNT_W-1:0]  cap_val_a,
    output logic [CNT_W-1:0]  cap_val_b,
    output logic [NUM_CH-1:0] cap_flag,
    output logic [NUM_CH-1:0] ovc_flag,
    output logic              ovf_flag,
    output logic              irq
);
    edge_pair_t        edges;
    meas_evt_t         mevt;
    logic              trig_evt;
    logic [NUM_CH-1:0] chan_evt;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  val_arr [NUM_CH];

    pwmm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sig_in),
        .edges    (edges)
    );

    assign mevt     = classify_edges(edges, trig_on_fall);
    assign trig_evt = mevt.trig;
    assign chan_evt = route_events(mevt, swap_route);

    pwmm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (trig_evt),
        .count   (cnt_q),
        .sat     (ovf_flag)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmm_capture_ch #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .evt    (chan_evt[i]),
            .enable (cap_en[i]),
            .clr    (flag_clr[i]),
            .count  (cnt_q),
            .value  (val_arr[i]),
            .flag   (cap_flag[i]),
            .ovc    (ovc_flag[i])
        );
    end

    assign cap_val_a = val_arr[0];
    assign cap_val_b = val_arr[1];
    assign irq       = |(cap_flag & irq_en);
endmodule

// File: rtl/pwm_meter_chk.sv
module pwm_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             edge_rise,
    input logic             edge_fall,
    input logic             trig,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic [1:0]       chan_evt,
    input logic [1:0]       cap_en,
    input logic [1:0]       flag_clr,
    input logic [CNT_W-1:0] cap_val_a,
    input logic [1:0]       cap_flag,
    input logic [1:0]       ovc,
    input logic [1:0]       irq_en,
    input logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_edges_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edge_rise, edge_fall}));

    p_trig_restart_r2: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == '0 && !ovf));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !trig) |=> (cnt == CNT_MAX && ovf));

    p_cap_load_r6: assert property (@(posedge clk) disable iff (rst)
        (chan_evt[0] && cap_en[0]) |=> (cap_val_a == $past(cnt)));

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !cap_en[0] |=> $stable(cap_val_a));

    p_clear_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr[1] && !(chan_evt[1] && cap_en[1])) |=> !cap_flag[1]);

    p_ovc_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovc[0]) |-> $past(cap_flag[0]));

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 2'b00) |-> !irq);
endmodule

bind pwm_meter pwm_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .edge_rise (edges.rise),
    .edge_fall (edges.fall),
    .trig      (trig_evt),
    .cnt       (cnt_q),
    .ovf       (ovf_flag),
    .chan_evt  (chan_evt),
    .cap_en    (cap_en),
    .flag_clr  (flag_clr),
    .cap_val_a (cap_val_a),
    .cap_flag  (cap_flag),
    .ovc       (ovc_flag),
    .irq_en    (irq_en),
    .irq       (irq)
);

// File: tb/pwm_meter_tb.sv
module pwm_meter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int CMAX       = (1 << CNT_W) - 1;
    localparam int NV         = 6;
    // {trig_on_fall, swap_route, active cycles, inactive cycles}
    localparam int VT [NV][4] = '{
        '{0, 0,  5,  7},
        '{0, 1,  3,  9},
        '{1, 0,  4,  6},
        '{1, 1, 10,  2},
        '{0, 0,  1,  1},
        '{1, 0, 20, 30}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sig_in = 1'b0;
    logic             trig_on_fall = 1'b0;
    logic             swap_route = 1'b0;
    logic [1:0]       cap_en = 2'b00;
    logic [1:0]       irq_en = 2'b00;
    logic [1:0]       flag_clr = 2'b00;
    logic [CNT_W-1:0] cap_val_a;
    logic [CNT_W-1:0] cap_val_b;
    logic [1:0]       cap_flag;
    logic [1:0]       ovc_flag;
    logic             ovf_flag;
    logic             irq;

    int n_run  = 0;
    int n_fail = 0;

    pwm_meter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .trig_on_fall(trig_on_fall),
        .swap_route(swap_route), .cap_en(cap_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .cap_val_a(cap_val_a), .cap_val_b(cap_val_b),
        .cap_flag(cap_flag), .ovc_flag(ovc_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        step(1);
        flag_clr = 2'b00;
    endtask

    task automatic run_wave(input int fall, input int act_c, input int inact_c, input int n);
        for (int p = 0; p < n; p++) begin
            sig_in = (fall == 0);
            step(act_c);
            sig_in = (fall != 0);
            step(inact_c);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int old_b;
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk("R11 cap_val_a", int'(cap_val_a), 0);
        chk("R11 cap_val_b", int'(cap_val_b), 0);
        chk("R11 cap_flag", int'(cap_flag), 0);
        chk("R11 ovc_flag", int'(ovc_flag), 0);
        chk("R11 ovf_flag", int'(ovf_flag), 0);
        chk("R11 irq", int'(irq), 0);

        // R1 latency of a rising edge into channel 0
        cap_en = 2'b11;
        step(4);
        sig_in = 1'b1;
        step(2);
        chk("R1 flag not yet", int'(cap_flag[0]), 0);
        step(1);
        chk("R1 flag at third edge", int'(cap_flag[0]), 1);

        // R10 interrupt masking
        irq_en = 2'b00; step(1);
        chk("R10 irq masked", int'(irq), 0);
        irq_en = 2'b01; step(1);
        chk("R10 irq enabled", int'(irq), 1);
        irq_en = 2'b10; step(1);
        chk("R10 irq other channel", int'(irq), 0);
        irq_en = 2'b00;

        // R8 clear and capture in the same cycle
        sig_in = 1'b0;
        step(2);
        flag_clr = 2'b11;
        step(1);
        flag_clr = 2'b00;
        chk("R8 capture beats clear", int'(cap_flag), 2);
        chk("R9 no overcapture on fresh flag", int'(ovc_flag), 0);

        // R9 overcapture on channel 1
        sig_in = 1'b1; step(4);
        sig_in = 1'b0; step(4);
        chk("R9 overcapture ch1", int'(ovc_flag), 2);
        clear_flags();
        chk("R9 overcapture cleared", int'(ovc_flag), 0);
        chk("R8 flags cleared", int'(cap_flag), 0);

        // Table of waveforms: R2 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            int per;
            int pul;
            trig_on_fall = VT[v][0][0];
            swap_route   = VT[v][1][0];
            clear_flags();
            run_wave(VT[v][0], VT[v][2], VT[v][3], 3);
            step(4);
            per = VT[v][2] + VT[v][3] - 1;
            pul = VT[v][2] - 1;
            chk("R2/R4/R5/R6 channel 0 value", int'(cap_val_a), (VT[v][1] != 0) ? pul : per);
            chk("R2/R4/R5/R6 channel 1 value", int'(cap_val_b), (VT[v][1] != 0) ? per : pul);
            if (v == 0) begin
                chk("R8 both flags set", int'(cap_flag), 3);
                chk("R9 both overcaptures set", int'(ovc_flag), 3);
            end
        end

        // R7 disabled channel keeps its value
        clear_flags();
        cap_en = 2'b01;
        old_b = int'(cap_val_b);
        trig_on_fall = 1'b0;
        swap_route   = 1'b0;
        run_wave(0, 6, 6, 3);
        step(4);
        chk("R7 disabled value held", int'(cap_val_b), old_b);
        chk("R7 disabled flag clear", int'(cap_flag[1]), 0);
        chk("R7 enabled channel period", int'(cap_val_a), 11);

        // R3 saturation and release
        cap_en = 2'b11;
        clear_flags();
        step(CMAX + 20);
        chk("R3 overflow flag", int'(ovf_flag), 1);
        sig_in = 1'b1;
        step(3);
        chk("R3 saturated capture", int'(cap_val_a), CMAX);
        chk("R3 overflow released", int'(ovf_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule